// File: doc/BRIEF.md
# Flash Block Lock Guard

This block keeps the per-block protection state of an eight-block flash array and decides, for every array operation, whether it may proceed. Each block owns a small lock register with three control bits: one that blocks modification, one that hides the block's contents from reads, and one that freezes the other two (and itself) until the next reset. Software reaches these registers through a simple read/write register port decoded from a 32-bit address. The same port also exposes a read-only register that returns the level of five general-purpose input pins.

Array requests (read, program, erase) arrive with a block index. The guard combines the addressed block's lock bits with three board-level protection inputs: a program-voltage-low indication that protects everything, a top-block enable and a main-blocks enable. It answers with a same-cycle allow signal. A read of a read-locked block yields 00h instead of the array byte. A rejected program or erase latches a sticky error flag that stays set until an explicit clear or reset.

Top module: `blk_lock_guard`

## Requirements
- R1: After reset every lock register reads 01h (modify-lock set, read-lock clear, freeze clear), `err_flag` is 0 and `reg_rdata` is 00h.
- R2: The lock register of block n (n = 0..7) is at address FFB8_0002h + n·0001_0000h. A read of any address that maps neither to a lock register nor to the GPI register returns 00h. A write to such an address changes no register.
- R3: Lock register layout: bit 0 is the modify lock, bit 1 is the freeze bit and bit 2 is the read lock. Bits 7..3 always read 0 and ignore writes.
- R4: `op_kind` codes are 0 = read, 1 = program, 2 = erase and 3 = treated as erase. While block b's modify lock is 1, any nonzero `op_kind` to block b gives `op_allow` = 0. A rejected modify with `op_valid` = 1 sets `err_flag`. An allowed one does not, and reads never do.
- R5: For `op_kind` = 0, `op_allow` is the inverse of the block's read lock. `op_rdata` equals `arr_rdata` when the read is allowed and 00h when it is not.
- R6: While a block's freeze bit is 1, writes to its lock register are ignored. Only reset clears the freeze.
- R7: While `vpp_low` = 1, every modify request is refused whatever the lock bits hold.
- R8: While `top_en_n` is low, modify requests to block 7 are refused. While `main_en_n` is low, modify requests to blocks 0..6 are refused. Each input affects only its own blocks.
- R9: The register at FFBC_0100h returns `gpi` in bits 4..0, with bits 7..5 at 0. Writes to it have no effect.
- R10: `err_flag` holds until `err_clr` is high on a clock edge. A new rejection in the same cycle as `err_clr` wins and leaves the flag set.
- R11: `reg_rdata` takes the selected value, including the GPI pins sampled at that edge, on the clock edge where `reg_rd` is high. It holds that value until the next read. `op_allow` and `op_rdata` are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 32 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| op_valid | input | 1 | Array operation presented this cycle |
| op_kind | input | 2 | 0 read, 1 program, 2 erase, 3 as erase |
| op_blk | input | 3 | Target block index |
| arr_rdata | input | 8 | Byte read from the array |
| op_allow | output | 1 | Operation permitted |
| op_rdata | output | 8 | Read data after read-lock masking |
| vpp_low | input | 1 | Program voltage below threshold, protects all blocks |
| top_en_n | input | 1 | Low protects block 7 |
| main_en_n | input | 1 | Low protects blocks 0..6 |
| gpi | input | 5 | General-purpose input pins |
| err_clr | input | 1 | Clears the sticky error flag |
| err_flag | output | 1 | Sticky rejected-modify flag |

## Verification
Register writes take effect on the edge where `reg_wr` is high. A read strobed on the next edge returns the new value one cycle after its strobe. The bench drives each strobe at a falling edge and samples `reg_rdata` at the following falling edge. The permission and masked-read outputs have no register in their path, so they are checked 1 ns after the inputs change, with no clock edge in between. The error flag is due on the edge that sees the rejected request, and the bench reads it at the falling edge after. Holding of read data is checked several idle cycles after the read, with the GPI pins moved.

// File: rtl/flk_pkg.sv
// Package: shared encodings for the flash block lock guard.
// Assumes: operation codes are 2 bits wide; any nonzero code modifies the array.
package flk_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_ERAX  = 2'd3
    } op_kind_e;

    // Per-block lock state; packed so that {rd_lock, freeze, wr_lock} maps to bits 2..0.
    typedef struct packed {
        logic rd_lock;
        logic freeze;
        logic wr_lock;
    } lock_bits_t;

    localparam int LOCK_FIELD_W = 3;

endpackage

// File: rtl/flk_addr_dec.sv
// Module: flk_addr_dec
// Decodes a register address into a lock-register hit with block index, or a
// GPI-register hit. Assumes lock registers sit at BASE + n * 2**STRIDE_LOG2.
module flk_addr_dec #(
    parameter int          AW          = 32,
    parameter int          NB          = 8,
    parameter int          BW          = 3,
    parameter int          STRIDE_LOG2 = 16,
    parameter logic [31:0] LOCK_BASE   = 32'hFFB8_0002,
    parameter logic [31:0] GPI_ADDR    = 32'hFFBC_0100
) (
    input  logic [AW-1:0] addr,
    output logic          lock_hit,
    output logic [BW-1:0] lock_blk,
    output logic          gpi_hit
);
    localparam int HW = AW - STRIDE_LOG2;

    logic [AW-1:0] offset;
    logic [HW-1:0] slot;

    // Offset from the lock window base; wraps to a large value below the base.
    always_comb begin
        offset = addr - LOCK_BASE[AW-1:0];
        slot   = offset[AW-1:STRIDE_LOG2];
    end

    // Lock hit needs an exact stride alignment and a slot inside the block count.
    always_comb begin
        lock_hit = (offset[STRIDE_LOG2-1:0] == '0) && (slot < HW'(NB));
        lock_blk = slot[BW-1:0];
        gpi_hit  = (addr == GPI_ADDR[AW-1:0]);
    end

endmodule

// File: rtl/flk_lock_reg.sv
// Module: flk_lock_reg
// One block's lock register. Resets to modify-locked; once the freeze bit is
// set, all writes are dropped until reset. Assumes write data is pre-sliced.
module flk_lock_reg
    import flk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  lock_bits_t wr_val,
    output lock_bits_t q
);
    // Holds the lock state; freeze gates every later write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.wr_lock <= 1'b1;
            q.freeze  <= 1'b0;
            q.rd_lock <= 1'b0;
        end else if (wr_en && !q.freeze) begin
            q <= wr_val;
        end
    end

endmodule

// File: rtl/flk_prot_eval.sv
// Module: flk_prot_eval
// Combinational permission check for one array operation. Assumes block NB-1
// is the top block and all lower blocks form the main area.
module flk_prot_eval
    import flk_pkg::*;
#(
    parameter int NB = 8,
    parameter int BW = 3,
    parameter int DW = 8
) (
    input  logic [NB-1:0] wr_lock_v,
    input  logic [NB-1:0] rd_lock_v,
    input  logic [1:0]    op_kind,
    input  logic [BW-1:0] op_blk,
    input  logic [DW-1:0] arr_rdata,
    input  logic          vpp_low,
    input  logic          top_en_n,
    input  logic          main_en_n,
    output logic          is_modify,
    output logic          allow,
    output logic [DW-1:0] rdata
);
    localparam logic [BW-1:0] TOP_BLK = BW'(NB - 1);

    logic in_range;
    logic blk_wl;
    logic blk_rl;
    logic pin_block;

    // Select the addressed block's lock bits; out-of-range indices count as locked.
    always_comb begin
        in_range = (op_blk <= TOP_BLK);
        blk_wl   = in_range ? wr_lock_v[op_blk] : 1'b1;
        blk_rl   = in_range ? rd_lock_v[op_blk] : 1'b1;
    end

    // Board-level inputs: supply, top-block enable, main-blocks enable.
    always_comb begin
        pin_block = vpp_low ||
                    ((op_blk == TOP_BLK) ? !top_en_n : !main_en_n);
    end

    // Final decision and masked read data.
    always_comb begin
        is_modify = (op_kind != OP_READ);
        if (is_modify) begin
            allow = !blk_wl && !pin_block;
        end else begin
            allow = !blk_rl;
        end
        rdata = (!is_modify && allow) ? arr_rdata : '0;
    end

endmodule

// File: rtl/blk_lock_guard.sv
// Module: blk_lock_guard (top)
// Lock register file, register port, GPI register and operation guard for a
// multi-block flash. Assumes single-cycle register strobes; a read and a write
// in the same cycle return the value before the write.
module blk_lock_guard
    import flk_pkg::*;
#(
    parameter int          NB          = 8,
    parameter int          AW          = 32,
    parameter int          DW          = 8,
    parameter int          GPI_W       = 5,
    parameter int          STRIDE_LOG2 = 16,
    parameter logic [31:0] LOCK_BASE   = 32'hFFB8_0002,
    parameter logic [31:0] GPI_ADDR    = 32'hFFBC_0100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic             op_valid,
    input  logic [1:0]       op_kind,
    input  logic [$clog2(NB)-1:0] op_blk,
    input  logic [DW-1:0]    arr_rdata,
    output logic             op_allow,
    output logic [DW-1:0]    op_rdata,
    input  logic             vpp_low,
    input  logic             top_en_n,
    input  logic             main_en_n,
    input  logic [GPI_W-1:0] gpi,
    input  logic             err_clr,
    output logic             err_flag
);
    localparam int BW = $clog2(NB);

    logic          lock_hit;
    logic [BW-1:0] lock_blk;
    logic          gpi_hit;
    lock_bits_t    wr_val;
    lock_bits_t    lk_q [NB];
    logic [NB-1:0] wl_v;
    logic [NB-1:0] rl_v;
    logic          is_modify;
    logic          reject;
    logic [DW-1:0] rd_next;

    flk_addr_dec #(
        .AW(AW), .NB(NB), .BW(BW), .STRIDE_LOG2(STRIDE_LOG2),
        .LOCK_BASE(LOCK_BASE), .GPI_ADDR(GPI_ADDR)
    ) dec_i (
        .addr(reg_addr),
        .lock_hit(lock_hit),
        .lock_blk(lock_blk),
        .gpi_hit(gpi_hit)
    );

    // Slice the write byte into lock fields; upper bits are discarded.
    always_comb begin
        wr_val = reg_wdata[LOCK_FIELD_W-1:0];
    end

    genvar gi;
    generate
        for (gi = 0; gi < NB; gi++) begin : g_lock
            logic sel_wr;
            // Write strobe for this block only.
            always_comb sel_wr = reg_wr && lock_hit && (lock_blk == BW'(gi));

            flk_lock_reg lr_i (
                .clk(clk),
                .rst_n(rst_n),
                .wr_en(sel_wr),
                .wr_val(wr_val),
                .q(lk_q[gi])
            );

            // Flatten the lock state for the guard.
            always_comb begin
                wl_v[gi] = lk_q[gi].wr_lock;
                rl_v[gi] = lk_q[gi].rd_lock;
            end
        end
    endgenerate

    flk_prot_eval #(.NB(NB), .BW(BW), .DW(DW)) eval_i (
        .wr_lock_v(wl_v),
        .rd_lock_v(rl_v),
        .op_kind(op_kind),
        .op_blk(op_blk),
        .arr_rdata(arr_rdata),
        .vpp_low(vpp_low),
        .top_en_n(top_en_n),
        .main_en_n(main_en_n),
        .is_modify(is_modify),
        .allow(op_allow),
        .rdata(op_rdata)
    );

    // Read mux: GPI pins, a lock register, or zero for unmapped addresses.
    always_comb begin
        rd_next = '0;
        if (gpi_hit) begin
            rd_next[GPI_W-1:0] = gpi;
        end else if (lock_hit) begin
            rd_next[LOCK_FIELD_W-1:0] = lk_q[lock_blk];
        end
    end

    // Read data register; captures on a read strobe and holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_next;
        end
    end

    // A presented modify that the guard refuses.
    always_comb reject = op_valid && is_modify && !op_allow;

    // Sticky error flag; a new rejection outranks the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
        end else if (reject) begin
            err_flag <= 1'b1;
        end else if (err_clr) begin
            err_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/blk_lock_guard_chk.sv
// Module: blk_lock_guard_chk
// Port-level properties of blk_lock_guard, attached with bind below.
module blk_lock_guard_chk #(
    parameter int NB = 8,
    parameter int DW = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_rd,
    input logic [DW-1:0]         reg_rdata,
    input logic                  op_valid,
    input logic [1:0]            op_kind,
    input logic [$clog2(NB)-1:0] op_blk,
    input logic [DW-1:0]         arr_rdata,
    input logic                  op_allow,
    input logic [DW-1:0]         op_rdata,
    input logic                  vpp_low,
    input logic                  top_en_n,
    input logic                  main_en_n,
    input logic                  err_clr,
    input logic                  err_flag
);
    localparam int BW = $clog2(NB);

    // R7
    vpp_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_low && op_kind != 2'd0) |-> !op_allow);

    // R8
    top_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!top_en_n && op_blk == BW'(NB - 1) && op_kind != 2'd0) |-> !op_allow);

    // R8
    main_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!main_en_n && op_blk != BW'(NB - 1) && op_kind != 2'd0) |-> !op_allow);

    // R5
    rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == 2'd0 && !op_allow) |-> (op_rdata == '0));

    // R5
    rd_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == 2'd0 && op_allow) |-> (op_rdata == arr_rdata));

    // R4
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind != 2'd0 && !op_allow) |=> err_flag);

    // R10
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);

    // R10
    err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !(op_valid && op_kind != 2'd0 && !op_allow)) |=> !err_flag);

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

endmodule

bind blk_lock_guard blk_lock_guard_chk #(.NB(NB), .DW(DW)) chk_i (
    .clk(clk),
    .rst_n(rst_n),
    .reg_rd(reg_rd),
    .reg_rdata(reg_rdata),
    .op_valid(op_valid),
    .op_kind(op_kind),
    .op_blk(op_blk),
    .arr_rdata(arr_rdata),
    .op_allow(op_allow),
    .op_rdata(op_rdata),
    .vpp_low(vpp_low),
    .top_en_n(top_en_n),
    .main_en_n(main_en_n),
    .err_clr(err_clr),
    .err_flag(err_flag)
);

// File: tb/blk_lock_guard_tb_top.sv
// Bench: sweeps every lock value on every block against all pin and operation
// combinations, plus freeze, unmapped, GPI, error and hold cases.
module blk_lock_guard_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = '0;
    logic [2:0]  op_blk = '0;
    logic [7:0]  arr_rdata = '0;
    logic        op_allow;
    logic [7:0]  op_rdata;
    logic        vpp_low = 1'b0;
    logic        top_en_n = 1'b1;
    logic        main_en_n = 1'b1;
    logic [4:0]  gpi = '0;
    logic        err_clr = 1'b0;
    logic        err_flag;

    int total = 0;
    int bad = 0;
    logic m_wl [8];
    logic m_rl [8];

    always #2.5 clk = ~clk;

    blk_lock_guard dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .op_valid(op_valid), .op_kind(op_kind), .op_blk(op_blk),
        .arr_rdata(arr_rdata), .op_allow(op_allow), .op_rdata(op_rdata),
        .vpp_low(vpp_low), .top_en_n(top_en_n), .main_en_n(main_en_n),
        .gpi(gpi), .err_clr(err_clr), .err_flag(err_flag)
    );

    function automatic logic [31:0] lk_addr(input int b);
        return 32'hFFB8_0002 + (32'(b) << 16);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [7:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 rdata", 32'(reg_rdata), 32'h0);
        check("R1 err", 32'(err_flag), 32'h0);
        for (int b = 0; b < 8; b++) begin
            rd(lk_addr(b), d);
            check("R1 lock reset", 32'(d), 32'h01);
        end

        // R2 R3 R4 R5 R7 R8: all non-freezing values on all blocks, all pins and kinds
        for (int b = 0; b < 8; b++) begin
            for (int v = 0; v < 256; v++) begin
                if (v[1] == 1'b0) begin
                    wr(lk_addr(b), 8'(v));
                    rd(lk_addr(b), d);
                    check("R3 field readback", 32'(d), 32'(v & 5));
                    m_wl[b] = v[0];
                    m_rl[b] = v[2];
                    for (int p = 0; p < 8; p++) begin
                        for (int k = 0; k < 4; k++) begin
                            logic ea;
                            vpp_low = p[0]; top_en_n = p[1]; main_en_n = p[2];
                            op_blk = 3'(b); op_kind = 2'(k);
                            arr_rdata = 8'(v ^ (p * 37) ^ 8'h5A);
                            if (k == 0) ea = !m_rl[b];
                            else ea = !m_wl[b] && !p[0] && ((b == 7) ? p[1] : p[2]);
                            #1;
                            if (k == 0) begin
                                check("R5 read allow", 32'(op_allow), 32'(ea));
                                check("R5 read data", 32'(op_rdata), ea ? 32'(arr_rdata) : 32'h0);
                            end else if (p[0]) begin
                                check("R7 supply protect", 32'(op_allow), 32'(ea));
                            end else if ((b == 7 && !p[1]) || (b != 7 && !p[2])) begin
                                check("R8 pin protect", 32'(op_allow), 32'(ea));
                            end else begin
                                check("R4 modify lock", 32'(op_allow), 32'(ea));
                            end
                        end
                    end
                    vpp_low = 1'b0; top_en_n = 1'b1; main_en_n = 1'b1; op_kind = 2'd0;
                end
            end
        end
        // every block now holds 05h

        // R4 R10: error flag behaviour
        wr(lk_addr(3), 8'h00);
        @(negedge clk);
        op_valid = 1'b1; op_kind = 2'd1; op_blk = 3'd3;
        @(negedge clk);
        op_valid = 1'b0;
        check("R4 allowed no err", 32'(err_flag), 32'h0);
        op_valid = 1'b1; op_kind = 2'd0; op_blk = 3'd2;
        @(negedge clk);
        op_valid = 1'b0;
        check("R4 read no err", 32'(err_flag), 32'h0);
        op_valid = 1'b1; op_kind = 2'd2; op_blk = 3'd2;
        @(negedge clk);
        op_valid = 1'b0;
        check("R4 reject sets err", 32'(err_flag), 32'h1);
        repeat (3) @(negedge clk);
        check("R10 err sticky", 32'(err_flag), 32'h1);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        check("R10 err cleared", 32'(err_flag), 32'h0);
        err_clr = 1'b1; op_valid = 1'b1; op_kind = 2'd1; op_blk = 3'd6;
        @(negedge clk);
        err_clr = 1'b0; op_valid = 1'b0;
        check("R10 set beats clear", 32'(err_flag), 32'h1);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        vpp_low = 1'b1; op_valid = 1'b1; op_kind = 2'd3; op_blk = 3'd3;
        @(negedge clk);
        op_valid = 1'b0; vpp_low = 1'b0;
        check("R7 supply reject sets err", 32'(err_flag), 32'h1);

        // R6: freeze
        wr(lk_addr(5), 8'h00);
        wr(lk_addr(5), 8'h02);
        rd(lk_addr(5), d);
        check("R6 freeze set", 32'(d), 32'h02);
        wr(lk_addr(5), 8'h05);
        rd(lk_addr(5), d);
        check("R6 frozen write ignored", 32'(d), 32'h02);
        wr(lk_addr(5), 8'h00);
        rd(lk_addr(5), d);
        check("R6 frozen clear ignored", 32'(d), 32'h02);
        op_kind = 2'd1; op_blk = 3'd5;
        #1;
        check("R6 frozen unlocked allows", 32'(op_allow), 32'h1);
        op_kind = 2'd0;
        wr(lk_addr(6), 8'h07);
        wr(lk_addr(6), 8'h00);
        rd(lk_addr(6), d);
        check("R6 frozen all bits", 32'(d), 32'h07);
        do_reset();
        rd(lk_addr(5), d);
        check("R6 reset unfreezes", 32'(d), 32'h01);
        rd(lk_addr(6), d);
        check("R6 reset unfreezes", 32'(d), 32'h01);
        wr(lk_addr(6), 8'h04);
        rd(lk_addr(6), d);
        check("R6 writable after reset", 32'(d), 32'h04);
        wr(lk_addr(6), 8'h01);

        // R2: unmapped addresses
        begin
            logic [31:0] um [6];
            um[0] = 32'hFFB8_0003; um[1] = 32'hFFB8_0000; um[2] = 32'hFFC0_0002;
            um[3] = 32'hFFB7_0002; um[4] = 32'hFFB8_1002; um[5] = 32'h0000_0002;
            for (int i = 0; i < 6; i++) begin
                wr(um[i], 8'h04);
                rd(um[i], d);
                check("R2 unmapped reads zero", 32'(d), 32'h0);
            end
            for (int b = 0; b < 8; b++) begin
                rd(lk_addr(b), d);
                check("R2 unmapped write no effect", 32'(d), 32'h01);
            end
        end

        // R9: GPI register
        for (int g = 0; g < 32; g++) begin
            gpi = 5'(g);
            rd(32'hFFBC_0100, d);
            check("R9 gpi read", 32'(d), 32'(g));
        end
        gpi = 5'h13;
        wr(32'hFFBC_0100, 8'hFF);
        rd(32'hFFBC_0100, d);
        check("R9 gpi write ignored", 32'(d), 32'h13);
        rd(lk_addr(2), d);
        check("R9 write missed lock regs", 32'(d), 32'h01);

        // R11: read timing and hold
        gpi = 5'h05;
        rd(32'hFFBC_0100, d);
        gpi = 5'h1A;
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = lk_addr(0);
        #1;
        check("R11 no early update", 32'(reg_rdata), 32'h05);
        @(negedge clk);
        reg_rd = 1'b0;
        check("R11 update after edge", 32'(reg_rdata), 32'h01);
        repeat (3) @(negedge clk);
        check("R11 held", 32'(reg_rdata), 32'h01);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(150000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule